// File: doc/BRIEF.md
# Periodic ADC Delay-Channel Scheduler

This block holds four programmable delay timers that pace the conversions of an analog-to-digital converter. Each timer counts a slow tick that is supplied from outside. When its count runs out, the timer raises a one-cycle conversion request on every ADC slot that is set in its 8-bit slot mask. It then reloads its delay and repeats for a programmed number of extra rounds. After the last round it stops. At that same expiry it can restart any set of the four timers, itself included, so timers can chain into each other or run without end.

Software programs a timer with one 32-bit word, written to the timer chosen by `wr_sel`. A word with the start bit set loads the timer and starts it. A word with the start bit clear stores the fields and leaves the timer idle, or stops it if it was running. An all-zero word turns the timer off completely. At a 2000 Hz tick, a delay of 200 gives one expiry every 100 ms.

Top module: `adcsch_top`

## Requirements
- R1: After reset is asserted, `slot_trig` and `peer_trig` are zero. No timer runs until a word with the start bit set is written to it.
- R2: The word fields are: delay in bits 10:0, extra-round count in bits 15:11, timer-restart mask in bits 19:16 (bit 16+j selects timer j), start bit 20, and slot mask in bits 31:24 (bit 24+k selects slot k). Once a word with bit 20 set is written and the write is complete, the first expiry happens on tick number max(D,1). On that tick `slot_trig` equals the slot mask.
- R3: After an expiry that is not the last, each following expiry comes exactly max(D,1) ticks later.
- R4: With an extra-round count of L, a started timer expires L+1 times. It then stops unless it is restarted.
- R5: `peer_trig` pulses only on the tick of a timer's last expiry, and there it equals that timer's restart mask.
- R6: A timer selected through `peer_trig` restarts from its stored fields, even if it was idle. Its first expiry comes max(D,1) ticks after the restarting tick.
- R7: A timer whose restart mask selects itself keeps expiring every max(D,1) ticks without end.
- R8: Writing a word with bit 20 clear to a running timer stops it. An all-zero word leaves the timer producing no requests.
- R9: Cycles with `tick` low do not advance any count and produce no pulses.
- R10: When several timers expire on the same tick, `slot_trig` is the OR of their slot masks.
- R11: A delay of 0 behaves like a delay of 1: the timer expires on every tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Slow time-base enable, one cycle wide |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | 2 | Timer targeted by the write |
| wr_data | input | 32 | Configuration word |
| slot_trig | output | 8 | Conversion request per ADC slot, one cycle |
| peer_trig | output | 4 | Restart request per timer, one cycle |

## Verification
Single timers are run with a middle delay and several rounds, a zero delay, and a self-restart. These runs separate first-expiry latency, period and round count from one another. Two timers that start together and overlap show whether their slot masks merge by OR. An idle timer restarted by another shows whether restart fires only on the last round and whether it reloads the stored fields. Long gaps with `tick` low, a stop word issued mid-run, and a reset issued mid-run show that a timer neither advances nor fires when it should not.

// File: rtl/adcsch_pkg.sv
package adcsch_pkg;
  localparam int NCHAN    = 4;
  localparam int NSLOT    = 8;
  localparam int DLY_W    = 11;
  localparam int LOOP_W   = 5;
  localparam int WORD_W   = 32;
  localparam int SEL_W    = $clog2(NCHAN);
  localparam int DLY_LSB  = 0;
  localparam int LOOP_LSB = DLY_LSB + DLY_W;
  localparam int RST_LSB  = LOOP_LSB + LOOP_W;
  localparam int KICK_BIT = RST_LSB + NCHAN;
  localparam int SLOT_LSB = 24;

  typedef struct packed {
    logic [NSLOT-1:0]  slots;
    logic [NCHAN-1:0]  restart;
    logic [LOOP_W-1:0] rounds;
    logic [DLY_W-1:0]  dly;
  } tmr_cfg_t;

  function automatic tmr_cfg_t word_to_cfg(input logic [WORD_W-1:0] w);
    tmr_cfg_t c;
    c.dly     = w[DLY_LSB  +: DLY_W];
    c.rounds  = w[LOOP_LSB +: LOOP_W];
    c.restart = w[RST_LSB  +: NCHAN];
    c.slots   = w[SLOT_LSB +: NSLOT];
    return c;
  endfunction

  function automatic logic word_kick(input logic [WORD_W-1:0] w);
    return w[KICK_BIT];
  endfunction

  // A count of 0 or 1 expires on the current tick.
  function automatic logic count_spent(input logic [DLY_W-1:0] c);
    return (c >> 1) == '0;
  endfunction

  function automatic logic [DLY_W-1:0] count_next(input logic [DLY_W-1:0] c);
    return c - 1'b1;
  endfunction

  function automatic logic [LOOP_W-1:0] rounds_next(input logic [LOOP_W-1:0] r);
    return r - 1'b1;
  endfunction
endpackage

// File: rtl/adcsch_chan.sv
module adcsch_chan
  import adcsch_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_hit,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              restart_in,
  output logic              expire,
  output logic              last_exp,
  output logic              running,
  output logic [NSLOT-1:0]  slot_fire,
  output logic [NCHAN-1:0]  restart_fire,
  output logic [DLY_W-1:0]  cnt_o
);
  tmr_cfg_t          cfg_q;
  logic              kick_q;
  logic [DLY_W-1:0]  cnt_q;
  logic [LOOP_W-1:0] left_q;

  assign expire       = kick_q && tick && count_spent(cnt_q);
  assign last_exp     = expire && (left_q == '0);
  assign running      = kick_q;
  assign slot_fire    = expire   ? cfg_q.slots   : '0;
  assign restart_fire = last_exp ? cfg_q.restart : '0;
  assign cnt_o        = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      kick_q <= 1'b0;
      cnt_q  <= '0;
      left_q <= '0;
    end else if (wr_hit) begin
      cfg_q  <= word_to_cfg(wr_word);
      kick_q <= word_kick(wr_word);
      cnt_q  <= word_to_cfg(wr_word).dly;
      left_q <= word_to_cfg(wr_word).rounds;
    end else if (restart_in) begin
      kick_q <= 1'b1;
      cnt_q  <= cfg_q.dly;
      left_q <= cfg_q.rounds;
    end else if (expire) begin
      cnt_q <= cfg_q.dly;
      if (left_q == '0) kick_q <= 1'b0;
      else              left_q <= rounds_next(left_q);
    end else if (kick_q && tick) begin
      cnt_q <= count_next(cnt_q);
    end
  end
endmodule

// File: rtl/adcsch_fanin.sv
module adcsch_fanin
  import adcsch_pkg::*;
#(
  parameter int NCH = NCHAN
) (
  input  logic [NCH*NSLOT-1:0] slot_bus,
  input  logic [NCH*NCH-1:0]   restart_bus,
  output logic [NSLOT-1:0]     slot_or,
  output logic [NCH-1:0]       restart_or
);
  always_comb begin
    slot_or    = '0;
    restart_or = '0;
    for (int i = 0; i < NCH; i++) begin
      slot_or    = slot_or    | slot_bus[i*NSLOT +: NSLOT];
      restart_or = restart_or | restart_bus[i*NCH +: NCH];
    end
  end
endmodule

// File: rtl/adcsch_top.sv
module adcsch_top
  import adcsch_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  output logic [NSLOT-1:0]  slot_trig,
  output logic [NCHAN-1:0]  peer_trig
);
  logic [NCHAN-1:0]       expire_w;
  logic [NCHAN-1:0]       last_w;
  logic [NCHAN-1:0]       run_w;
  logic [NCHAN*NSLOT-1:0] slot_bus;
  logic [NCHAN*NCHAN-1:0] rst_bus;
  logic [NCHAN*DLY_W-1:0] cnt_bus;

  for (genvar g = 0; g < NCHAN; g++) begin : g_chan
    adcsch_chan u_chan (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick         (tick),
      .wr_hit       (wr_en && (wr_sel == SEL_W'(g))),
      .wr_word      (wr_data),
      .restart_in   (peer_trig[g]),
      .expire       (expire_w[g]),
      .last_exp     (last_w[g]),
      .running      (run_w[g]),
      .slot_fire    (slot_bus[g*NSLOT +: NSLOT]),
      .restart_fire (rst_bus[g*NCHAN +: NCHAN]),
      .cnt_o        (cnt_bus[g*DLY_W +: DLY_W])
    );
  end

  adcsch_fanin #(.NCH(NCHAN)) u_fanin (
    .slot_bus    (slot_bus),
    .restart_bus (rst_bus),
    .slot_or     (slot_trig),
    .restart_or  (peer_trig)
  );
endmodule

// File: rtl/adcsch_chk.sv
module adcsch_chk
  import adcsch_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              wr_en,
  input logic [SEL_W-1:0]  wr_sel,
  input logic [WORD_W-1:0] wr_data,
  input logic [NSLOT-1:0]  slot_trig,
  input logic [NCHAN-1:0]  peer_trig,
  input logic [NCHAN-1:0]  expire,
  input logic [NCHAN-1:0]  last_exp,
  input logic [NCHAN-1:0]  running,
  input logic [NCHAN*DLY_W-1:0] cnt_bus
);
  a_r9_quiet_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |-> (slot_trig == '0 && peer_trig == '0));

  a_r9_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> $stable(cnt_bus));

  a_r5_restart_only_last: assert property (@(posedge clk) disable iff (!rst_n)
    (peer_trig != '0) |-> (last_exp != '0));

  a_r10_slots_need_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    (expire == '0) |-> (slot_trig == '0));

  for (genvar i = 0; i < NCHAN; i++) begin : g_per
    a_r4_stop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      (last_exp[i] && !peer_trig[i] && !(wr_en && wr_sel == SEL_W'(i))) |=> !running[i]);

    a_r8_stop_word: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_W'(i) && !wr_data[KICK_BIT]) |=> !running[i]);

    a_r6_restart_runs: assert property (@(posedge clk) disable iff (!rst_n)
      (peer_trig[i] && !(wr_en && wr_sel == SEL_W'(i))) |=> running[i]);
  end
endmodule

bind adcsch_top adcsch_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .wr_data   (wr_data),
  .slot_trig (slot_trig),
  .peer_trig (peer_trig),
  .expire    (expire_w),
  .last_exp  (last_w),
  .running   (run_w),
  .cnt_bus   (cnt_bus)
);

// File: tb/test_adcsch_top.sv
module test_adcsch_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  slot_trig;
  logic [3:0]  peer_trig;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [11:0] expq[$];

  // scenario descriptors, tick indices relative to batch start
  int sd_on[4], sd_start[4], sd_dly[4], sd_rounds[4], sd_rep[4];
  logic [7:0] sd_slot[4];
  logic [3:0] sd_chain[4];

  always #(CLK_PERIOD/2) clk = ~clk;

  adcsch_top i_adcsch_top (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data),
    .slot_trig(slot_trig), .peer_trig(peer_trig)
  );

  function automatic logic [31:0] mk(int d, int l, logic [3:0] ch, bit k, logic [7:0] s);
    return {s, 3'b000, k, ch, 5'(l), 11'(d)};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int sel, logic [31:0] w);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_sel = 2'(sel); wr_data = w;
    @(posedge clk); #1;
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic clear_sd();
    for (int c = 0; c < 4; c++) begin
      sd_on[c] = 0; sd_start[c] = 0; sd_dly[c] = 1; sd_rounds[c] = 0;
      sd_rep[c] = 0; sd_slot[c] = '0; sd_chain[c] = '0;
    end
  endtask

  task automatic set_sd(int c, int st, int d, int l, int rep, logic [7:0] s, logic [3:0] ch);
    sd_on[c] = 1; sd_start[c] = st; sd_dly[c] = d; sd_rounds[c] = l;
    sd_rep[c] = rep; sd_slot[c] = s; sd_chain[c] = ch;
  endtask

  // driver: expected items derived from R2-R7, R10, R11
  task automatic plan(int n);
    for (int t = 1; t <= n; t++) begin
      logic [7:0] s; logic [3:0] p;
      s = '0; p = '0;
      for (int c = 0; c < 4; c++) begin
        int per, d, k;
        per = (sd_dly[c] < 1) ? 1 : sd_dly[c];
        d = t - sd_start[c];
        if (sd_on[c] != 0 && d > 0 && (d % per) == 0) begin
          k = d / per;
          if (sd_rep[c] != 0 || k <= sd_rounds[c] + 1) begin
            s = s | sd_slot[c];
            if ((k % (sd_rounds[c] + 1)) == 0) p = p | sd_chain[c];
          end
        end
      end
      expq.push_back({s, p});
    end
  endtask

  task automatic run_ticks(int n, int gap);
    for (int i = 0; i < n; i++) begin
      repeat (gap) @(posedge clk);
      #1 tick = 1'b1;
      @(posedge clk); #1 tick = 1'b0;
    end
  endtask

  // monitor: pops one expected item per tick cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (tick) begin
        if (expq.size() == 0) chk("R2 queue-underflow", 32'd1, 32'd0);
        else begin
          logic [11:0] e;
          e = expq.pop_front();
          chk("R2/R3/R4/R10 slot_trig", 32'(slot_trig), 32'(e[11:4]));
          chk("R5/R6 peer_trig", 32'(peer_trig), 32'(e[3:0]));
        end
      end else if (slot_trig != '0 || peer_trig != '0) begin
        chk("R9 pulse without tick", {20'd0, slot_trig, peer_trig}, 32'd0);
      end
    end
  end

  task automatic all_off();
    for (int c = 0; c < 4; c++) wr(c, 32'd0);
    clear_sd();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    clear_sd();
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 slot_trig in reset", 32'(slot_trig), 32'd0);
    chk("R1 peer_trig in reset", 32'(peer_trig), 32'd0);
    rst_n = 1'b1;
    plan(5); run_ticks(5, 1);

    // R2 R3 R4: delay 3, two extra rounds, slots A5
    wr(0, mk(3, 2, 4'b0000, 1, 8'hA5));
    set_sd(0, 0, 3, 2, 0, 8'hA5, 4'b0000);
    plan(14); run_ticks(14, 2);
    all_off();

    // R11: delay 0 fires every tick, three extra rounds
    wr(1, mk(0, 3, 4'b0000, 1, 8'h01));
    set_sd(1, 0, 0, 3, 0, 8'h01, 4'b0000);
    plan(7); run_ticks(7, 1);
    all_off();

    // R5 R6: timer2 restarts idle timer3 on its last expiry
    wr(3, mk(3, 0, 4'b0000, 0, 8'h80));
    wr(2, mk(2, 1, 4'b1000, 1, 8'h10));
    set_sd(2, 0, 2, 1, 0, 8'h10, 4'b1000);
    set_sd(3, 4, 3, 0, 0, 8'h80, 4'b0000);
    plan(10); run_ticks(10, 1);
    all_off();

    // R10: overlapping timers merge by OR
    wr(0, mk(2, 1, 4'b0000, 1, 8'h03));
    wr(1, mk(1, 3, 4'b0000, 1, 8'h0C));
    set_sd(0, 0, 2, 1, 0, 8'h03, 4'b0000);
    set_sd(1, 0, 1, 3, 0, 8'h0C, 4'b0000);
    plan(7); run_ticks(7, 1);
    all_off();

    // R7: self restart runs on
    wr(0, mk(2, 0, 4'b0001, 1, 8'h40));
    set_sd(0, 0, 2, 0, 1, 8'h40, 4'b0001);
    plan(8); run_ticks(8, 1);
    // R8: stop word with start bit clear
    wr(0, mk(2, 0, 4'b0001, 0, 8'h40));
    clear_sd();
    plan(6); run_ticks(6, 1);

    // R8: all-zero word silences a running timer
    wr(2, mk(1, 5, 4'b0000, 1, 8'h22));
    set_sd(2, 0, 1, 5, 0, 8'h22, 4'b0000);
    plan(2); run_ticks(2, 1);
    wr(2, 32'd0);
    clear_sd();
    plan(6); run_ticks(6, 1);

    // R9: long idle gaps do not advance the count
    wr(1, mk(2, 0, 4'b0000, 1, 8'h02));
    set_sd(1, 0, 2, 0, 0, 8'h02, 4'b0000);
    plan(4); run_ticks(4, 25);
    all_off();

    // R1: reset mid-run stops a self-restarting timer
    wr(0, mk(1, 0, 4'b0001, 1, 8'hFF));
    #1 rst_n = 1'b0;
    #(CLK_PERIOD);
    chk("R1 slot_trig after async reset", 32'(slot_trig), 32'd0);
    @(posedge clk); #1 rst_n = 1'b1;
    clear_sd();
    plan(5); run_ticks(5, 1);

    repeat (3) @(posedge clk);
    chk("R2 expected queue drained", 32'(expq.size()), 32'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule